// File: doc/BRIEF.md
# Synchronous Dual-Port RAM with Selectable Output Latency

This block is a two-port synchronous memory. Each port has its own clock, registered address and controls, and can read or write any word while the other port does the same, including the same word. Every control apart from output enable and the latency mode input is sampled on the rising edge of the port's clock.

Each port has an address front end with a small counter. On every edge this front end can clear the address to zero, load an external address, step to the next address, or keep the current one. Each port has two chip enables of opposite polarity, so that several devices can be banked without glue logic. A static mode input chooses between two output timings. In flow-through mode, read data appears in the cycle that follows the sampling edge. In pipelined mode it passes through one more register and appears a cycle later.

The pad drivers are modelled as a data bus plus a drive-valid flag. That flag is low whenever the output would be in high impedance.

Top module: `dpram_sync`

## Requirements
- R1: A port is selected at a rising edge only when `ce0_n` is 0 and `ce1` is 1. Any other combination does no access, and the port's output is not driven (`rvalid` = 0) in the output cycle that belongs to that edge. After reset both `rvalid` outputs are 0 and both `rdata` buses are zero.
- R2: On a selected edge, `rw` = 0 writes `wdata` to the current address and leaves the output undriven in that access's output cycle. `rw` = 1 reads the word.
- R3: `oe_n` acts without a clock. While it is 1, `rvalid` is 0 whatever the state of the port.
- R4: With `pipe` = 0, read data and `rvalid` = 1 appear in the cycle that follows the sampling edge. With `pipe` = 1 they appear one clock later.
- R5: The address used at each edge is chosen in this priority: `cnt_clr_n` = 0 gives zero; otherwise `ld_n` = 0 gives `addr`; otherwise `cnt_en_n` = 0 gives the previous address plus one, wrapping from the top address to zero; otherwise the previous address is kept. This choice is made whether the port is selected or not, and the chosen value becomes the new counter value.
- R6: When `ld_n`, `cnt_en_n` and `cnt_clr_n` are all held at 1, repeated reads return the same data.
- R7: Both ports can reach every address. A word written through one port is returned by a later read through the other port.
- R8: If one port writes a word on the same clock edge at which the other port reads that word, the read returns the old contents. The new contents are returned by the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of both ports' registers |
| clk_a | input | 1 | Port A clock |
| pipe_a | input | 1 | Port A latency mode, 1 = pipelined (static) |
| ce0_n_a | input | 1 | Port A chip enable, active low |
| ce1_a | input | 1 | Port A chip enable, active high |
| rw_a | input | 1 | Port A direction, 1 = read, 0 = write |
| oe_n_a | input | 1 | Port A output enable, active low, asynchronous |
| ld_n_a | input | 1 | Port A external address load, active low |
| cnt_en_n_a | input | 1 | Port A counter step, active low |
| cnt_clr_n_a | input | 1 | Port A counter clear, active low |
| addr_a | input | AW | Port A external address |
| wdata_a | input | DW | Port A write data |
| rdata_a | output | DW | Port A read data |
| rvalid_a | output | 1 | Port A output driven |
| clk_b | input | 1 | Port B clock |
| pipe_b | input | 1 | Port B latency mode, 1 = pipelined (static) |
| ce0_n_b | input | 1 | Port B chip enable, active low |
| ce1_b | input | 1 | Port B chip enable, active high |
| rw_b | input | 1 | Port B direction, 1 = read, 0 = write |
| oe_n_b | input | 1 | Port B output enable, active low, asynchronous |
| ld_n_b | input | 1 | Port B external address load, active low |
| cnt_en_n_b | input | 1 | Port B counter step, active low |
| cnt_clr_n_b | input | 1 | Port B counter clear, active low |
| addr_b | input | AW | Port B external address |
| wdata_b | input | DW | Port B write data |
| rdata_b | output | DW | Port B read data |
| rvalid_b | output | 1 | Port B output driven |

## Verification
The properties assume that a port's `pipe` input changes only after that port has been idle for at least two of its clock cycles, so every latency check sees one mode for the whole window. The stimulus changes modes only in idle gaps of several cycles. It never lets both ports write the same word on the same edge, since the outcome of that case is undefined. It also reads only words it has already written. The same-edge read and write case is produced by running the port B clock at an exact multiple of the port A period, with aligned rising edges.

// File: rtl/dpram_sync.sv
module dpram_sync #(
  parameter int AW = 5,
  parameter int DW = 9
) (
  input  logic          rst_n,
  input  logic          clk_a,
  input  logic          pipe_a,
  input  logic          ce0_n_a,
  input  logic          ce1_a,
  input  logic          rw_a,
  input  logic          oe_n_a,
  input  logic          ld_n_a,
  input  logic          cnt_en_n_a,
  input  logic          cnt_clr_n_a,
  input  logic [AW-1:0] addr_a,
  input  logic [DW-1:0] wdata_a,
  output logic [DW-1:0] rdata_a,
  output logic          rvalid_a,
  input  logic          clk_b,
  input  logic          pipe_b,
  input  logic          ce0_n_b,
  input  logic          ce1_b,
  input  logic          rw_b,
  input  logic          oe_n_b,
  input  logic          ld_n_b,
  input  logic          cnt_en_n_b,
  input  logic          cnt_clr_n_b,
  input  logic [AW-1:0] addr_b,
  input  logic [DW-1:0] wdata_b,
  output logic [DW-1:0] rdata_b,
  output logic          rvalid_b
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    bank_a [DEPTH];
  logic [DW-1:0]    bank_b [DEPTH];
  logic [DEPTH-1:0] tag_a, tag_b;

  logic [AW-1:0] ctr_a, ctr_b, eff_a, eff_b;
  logic [DW-1:0] word_a, word_b, q1_a, q1_b, q2_a, q2_b;
  logic          sel_a, sel_b, v1_a, v1_b, v2_a, v2_b;

  function automatic logic [AW-1:0] pick_addr(input logic clr_n, input logic ld_n,
                                              input logic en_n, input logic [AW-1:0] ext,
                                              input logic [AW-1:0] cur);
    if (!clr_n) return '0;
    if (!ld_n)  return ext;
    if (!en_n)  return cur + 1'b1;
    return cur;
  endfunction

  assign eff_a  = pick_addr(cnt_clr_n_a, ld_n_a, cnt_en_n_a, addr_a, ctr_a);
  assign eff_b  = pick_addr(cnt_clr_n_b, ld_n_b, cnt_en_n_b, addr_b, ctr_b);
  assign sel_a  = !ce0_n_a && ce1_a;
  assign sel_b  = !ce0_n_b && ce1_b;

  // equal tags: port A holds the newest copy of the word
  assign word_a = (tag_a[eff_a] == tag_b[eff_a]) ? bank_a[eff_a] : bank_b[eff_a];
  assign word_b = (tag_a[eff_b] == tag_b[eff_b]) ? bank_a[eff_b] : bank_b[eff_b];

  always_ff @(posedge clk_a) begin
    if (sel_a && !rw_a) bank_a[eff_a] <= wdata_a;
  end

  always_ff @(posedge clk_b) begin
    if (sel_b && !rw_b) bank_b[eff_b] <= wdata_b;
  end

  always_ff @(posedge clk_a or negedge rst_n) begin
    if (!rst_n) begin
      ctr_a <= '0;
      tag_a <= '0;
      q1_a  <= '0;
      q2_a  <= '0;
      v1_a  <= 1'b0;
      v2_a  <= 1'b0;
    end else begin
      ctr_a <= eff_a;
      if (sel_a && !rw_a) tag_a[eff_a] <= tag_b[eff_a];
      if (sel_a && rw_a) q1_a <= word_a;
      v1_a <= sel_a && rw_a;
      q2_a <= q1_a;
      v2_a <= v1_a;
    end
  end

  always_ff @(posedge clk_b or negedge rst_n) begin
    if (!rst_n) begin
      ctr_b <= '0;
      tag_b <= '0;
      q1_b  <= '0;
      q2_b  <= '0;
      v1_b  <= 1'b0;
      v2_b  <= 1'b0;
    end else begin
      ctr_b <= eff_b;
      if (sel_b && !rw_b) tag_b[eff_b] <= ~tag_a[eff_b];
      if (sel_b && rw_b) q1_b <= word_b;
      v1_b <= sel_b && rw_b;
      q2_b <= q1_b;
      v2_b <= v1_b;
    end
  end

  assign rdata_a  = pipe_a ? q2_a : q1_a;
  assign rdata_b  = pipe_b ? q2_b : q1_b;
  assign rvalid_a = (pipe_a ? v2_a : v1_a) && !oe_n_a;
  assign rvalid_b = (pipe_b ? v2_b : v1_b) && !oe_n_b;
endmodule

// File: rtl/dpram_sync_chk.sv
module dpram_sync_chk (
  input logic rst_n,
  input logic clk_a,
  input logic pipe_a,
  input logic ce0_n_a,
  input logic ce1_a,
  input logic rw_a,
  input logic oe_n_a,
  input logic rvalid_a,
  input logic clk_b,
  input logic pipe_b,
  input logic ce0_n_b,
  input logic ce1_b,
  input logic rw_b,
  input logic oe_n_b,
  input logic rvalid_b
);
  AST_OE_MUTES_A: assert property (@(posedge clk_a) disable iff (!rst_n)
    oe_n_a |-> !rvalid_a); // R3
  AST_OE_MUTES_B: assert property (@(posedge clk_b) disable iff (!rst_n)
    oe_n_b |-> !rvalid_b); // R3
  AST_DESEL_QUIET_A: assert property (@(posedge clk_a) disable iff (!rst_n)
    (!pipe_a && !(!ce0_n_a && ce1_a)) |=> !rvalid_a); // R1
  AST_DESEL_QUIET_B: assert property (@(posedge clk_b) disable iff (!rst_n)
    (!pipe_b && !(!ce0_n_b && ce1_b)) |=> !rvalid_b); // R1
  AST_WRITE_QUIET_A: assert property (@(posedge clk_a) disable iff (!rst_n)
    (!pipe_a && !ce0_n_a && ce1_a && !rw_a) |=> !rvalid_a); // R2
  AST_FLOW_LAT_A: assert property (@(posedge clk_a) disable iff (!rst_n)
    (!pipe_a && !ce0_n_a && ce1_a && rw_a) |=> (rvalid_a || oe_n_a)); // R4
  AST_PIPE_LAT_A: assert property (@(posedge clk_a) disable iff (!rst_n)
    (pipe_a && !ce0_n_a && ce1_a && rw_a) |-> ##2 (rvalid_a || oe_n_a)); // R4
  AST_PIPE_LAT_B: assert property (@(posedge clk_b) disable iff (!rst_n)
    (pipe_b && !ce0_n_b && ce1_b && rw_b) |-> ##2 (rvalid_b || oe_n_b)); // R4
endmodule

bind dpram_sync dpram_sync_chk chk_i (
  .rst_n(rst_n), .clk_a(clk_a), .pipe_a(pipe_a), .ce0_n_a(ce0_n_a), .ce1_a(ce1_a),
  .rw_a(rw_a), .oe_n_a(oe_n_a), .rvalid_a(rvalid_a),
  .clk_b(clk_b), .pipe_b(pipe_b), .ce0_n_b(ce0_n_b), .ce1_b(ce1_b),
  .rw_b(rw_b), .oe_n_b(oe_n_b), .rvalid_b(rvalid_b)
);

// File: tb/dpram_sync_tb_top.sv
module dpram_sync_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int AW = 5;
  localparam int DW = 9;
  localparam int DEPTH = 1 << AW;

  typedef struct {
    int             cyc;
    bit             drive;
    logic [DW-1:0]  data;
    string          req;
  } exp_t;

  logic rst_n = 1'b0;
  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic          pipe [2];
  logic          c0n [2];
  logic          c1 [2];
  logic          rw [2];
  logic          oen [2];
  logic          ldn [2];
  logic          cenn [2];
  logic          crn [2];
  logic [AW-1:0] adr [2];
  logic [DW-1:0] wd [2];
  logic [DW-1:0] rd [2];
  logic          rv [2];

  exp_t          q [2][$];
  logic [DW-1:0] mdl [DEPTH];
  int            ctrm [2];
  int            cyc_a = 0;
  int            cyc_b = 0;
  int            checks = 0;
  int            errors = 0;

  always #2 clk_a = ~clk_a;
  initial forever begin
    #2 clk_b = 1'b1;
    #4 clk_b = 1'b0;
    #2;
  end

  dpram_sync #(.AW(AW), .DW(DW)) dut_i (
    .rst_n(rst_n),
    .clk_a(clk_a), .pipe_a(pipe[0]), .ce0_n_a(c0n[0]), .ce1_a(c1[0]), .rw_a(rw[0]),
    .oe_n_a(oen[0]), .ld_n_a(ldn[0]), .cnt_en_n_a(cenn[0]), .cnt_clr_n_a(crn[0]),
    .addr_a(adr[0]), .wdata_a(wd[0]), .rdata_a(rd[0]), .rvalid_a(rv[0]),
    .clk_b(clk_b), .pipe_b(pipe[1]), .ce0_n_b(c0n[1]), .ce1_b(c1[1]), .rw_b(rw[1]),
    .oe_n_b(oen[1]), .ld_n_b(ldn[1]), .cnt_en_n_b(cenn[1]), .cnt_clr_n_b(crn[1]),
    .addr_b(adr[1]), .wdata_b(wd[1]), .rdata_b(rd[1]), .rvalid_b(rv[1])
  );

  always @(posedge clk_a) cyc_a <= cyc_a + 1;
  always @(posedge clk_b) cyc_b <= cyc_b + 1;

  function automatic int cyc_of(input int p);
    return (p == 0) ? cyc_a : cyc_b;
  endfunction

  task automatic mon(input int p);
    exp_t it;
    int   c = cyc_of(p);
    while (q[p].size() > 0 && q[p][0].cyc < c) begin
      it = q[p].pop_front();
      checks++; errors++;
      $display("FAIL %s port%0d: item for cycle %0d never checked, now %0d", it.req, p, it.cyc, c);
    end
    if (q[p].size() > 0 && q[p][0].cyc == c) begin
      it = q[p].pop_front();
      checks++;
      if (rv[p] !== it.drive || (it.drive && rd[p] !== it.data)) begin
        errors++;
        $display("FAIL %s port%0d cyc %0d: rvalid=%b rdata=%h expected rvalid=%b rdata=%h",
                 it.req, p, c, rv[p], rd[p], it.drive, it.data);
      end
    end else if (rst_n && rv[p] !== 1'b0) begin
      checks++; errors++;
      $display("FAIL R1 port%0d cyc %0d: rvalid=%b rdata=%h expected rvalid=0 (no access)",
               p, c, rv[p], rd[p]);
    end
  endtask

  always @(posedge clk_a) begin #1; mon(0); end
  always @(posedge clk_b) begin #1; mon(1); end

  task automatic idle_inputs(input int p);
    c0n[p] = 1'b1; c1[p] = 1'b1; rw[p] = 1'b1;
    ldn[p] = 1'b1; cenn[p] = 1'b1; crn[p] = 1'b1;
  endtask

  task automatic op(input int p, input bit ic0n, input bit ic1, input bit irw,
                    input bit ildn, input bit icenn, input bit icrn, input bit ioen,
                    input int ad, input int wv, input string r);
    exp_t it;
    int   eff;
    if (p == 0) @(negedge clk_a); else @(negedge clk_b);
    eff = !icrn ? 0 : !ildn ? ad : !icenn ? (ctrm[p] + 1) % DEPTH : ctrm[p];
    ctrm[p] = eff;
    c0n[p] = ic0n; c1[p] = ic1; rw[p] = irw; ldn[p] = ildn; cenn[p] = icenn;
    crn[p] = icrn; oen[p] = ioen; adr[p] = AW'(ad); wd[p] = DW'(wv);
    it.cyc   = cyc_of(p) + 1 + (pipe[p] ? 1 : 0);
    it.drive = !ic0n && ic1 && irw && !ioen;
    it.data  = mdl[eff];
    it.req   = r;
    q[p].push_back(it);
    if (!ic0n && ic1 && !irw) mdl[eff] = DW'(wv);
    if (p == 0) @(posedge clk_a); else @(posedge clk_b);
    #1.5;
    idle_inputs(p);
  endtask

  task automatic wr_ld(input int p, input int ad, input int wv, input string r);
    op(p, 0, 1, 0, 0, 1, 1, 0, ad, wv, r);
  endtask

  task automatic rd_ld(input int p, input int ad, input string r);
    op(p, 0, 1, 1, 0, 1, 1, 0, ad, 0, r);
  endtask

  task automatic gap();
    repeat (4) @(posedge clk_b);
  endtask

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < 2; p++) begin
      idle_inputs(p);
      oen[p] = 1'b0; adr[p] = '0; wd[p] = '0; ctrm[p] = 0;
    end
    pipe[0] = 1'b0;
    pipe[1] = 1'b1;
    repeat (3) @(posedge clk_b);
    @(negedge clk_a) rst_n = 1'b1;
    @(posedge clk_a); #1;
    for (int p = 0; p < 2; p++) begin
      checks++;
      if (rv[p] !== 1'b0 || rd[p] !== '0) begin
        errors++;
        $display("FAIL R1 reset port%0d: rvalid=%b rdata=%h expected rvalid=0 rdata=0", p, rv[p], rd[p]);
      end
    end

    for (int i = 0; i < 8; i++) wr_ld(0, i, 9'h0A0 + i * 7, "R2");
    rd_ld(0, 3, "R2");
    rd_ld(0, 6, "R4");
    rd_ld(1, 5, "R7");
    rd_ld(1, 0, "R4");

    rd_ld(0, 2, "R5");
    repeat (3) op(0, 0, 1, 1, 1, 0, 1, 0, 0, 0, "R5");
    repeat (2) op(0, 0, 1, 1, 1, 1, 1, 0, 0, 0, "R6");
    op(0, 0, 1, 1, 0, 0, 0, 0, 6, 0, "R5");

    op(0, 1, 1, 1, 0, 1, 1, 0, 4, 0, "R1");
    op(0, 0, 0, 1, 1, 1, 1, 0, 0, 0, "R1");
    op(0, 1, 0, 1, 1, 0, 1, 0, 0, 0, "R5");
    op(0, 0, 1, 1, 1, 1, 1, 0, 0, 0, "R5");

    op(0, 0, 1, 1, 0, 1, 1, 1, 1, 0, "R3");
    rd_ld(0, 1, "R3");

    wr_ld(1, 20, 9'h155, "R7");
    gap();
    rd_ld(0, 20, "R7");
    wr_ld(0, 21, 9'h0E1, "R7");
    rd_ld(1, 21, "R7");

    wr_ld(0, 9, 9'h033, "R8");
    gap();
    fork
      rd_ld(1, 9, "R8");
      begin
        @(negedge clk_b);
        wr_ld(0, 9, 9'h1CC, "R8");
      end
    join
    rd_ld(1, 9, "R8");

    wr_ld(0, DEPTH - 1, 9'h1A5, "R5");
    rd_ld(0, DEPTH - 1, "R5");
    op(0, 0, 1, 1, 1, 0, 1, 0, 0, 0, "R5");
    wr_ld(0, 10, 9'h011, "R5");
    op(0, 0, 1, 0, 1, 0, 1, 0, 0, 9'h122, "R5");
    rd_ld(0, 11, "R5");

    gap();
    pipe[0] = 1'b1;
    pipe[1] = 1'b0;
    gap();
    rd_ld(0, 3, "R4");
    rd_ld(0, 4, "R4");
    op(0, 0, 1, 1, 1, 0, 1, 0, 0, 0, "R5");
    rd_ld(1, 20, "R4");
    repeat (2) op(1, 0, 1, 1, 1, 1, 1, 0, 0, 0, "R6");
    op(1, 0, 1, 1, 0, 1, 1, 1, 9, 0, "R3");
    op(1, 0, 1, 0, 0, 1, 1, 0, 12, 9'h0C3, "R2");
    rd_ld(0, 12, "R7");

    gap();
    gap();
    for (int p = 0; p < 2; p++) begin
      checks++;
      if (q[p].size() != 0) begin
        errors++;
        $display("FAIL R4 port%0d: %0d results missing, expected 0", p, q[p].size());
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule